// File: doc/BRIEF.md
# Chunked Run-Length Pixel Expander

This block turns the payload of a run-length pixel write into a stream of single pixel writes, each with its own address. The command header has already been parsed before the block sees the payload. A one-cycle `start` pulse delivers the 24-bit start address, the total pixel count and the pixel width. The block then takes payload bytes one at a time over a valid/ready input. It emits one pixel per output handshake. Each pixel carries the next address after the previous one.

The payload is a sequence of chunks. A chunk opens with a literal-count byte, followed by that many literal pixels. It closes with a repeat byte, which says how many extra copies of the last literal to emit. Chunks continue until exactly the total has been produced. If the literals of a chunk complete the total, that chunk has no repeat byte and the block stops taking input. A literal count or repeat count that would pass the total is cut at the total, and a sticky overrun flag is raised. The final pixel of a command is marked with `out_last`.

Top module: `rle_pixel_expander`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `busy` and `overrun` are all low.
- R2: A `start` pulse taken while `busy` is low latches the start address. The k-th pixel emitted (counting from 0) carries address start + k, wrapping modulo 2^ADDR_W.
- R3: With `mode16` low, each literal is one byte, and the emitted pixel is that byte zero-extended to 16 bits.
- R4: With `mode16` high, each literal is two bytes, first byte in bits 15:8 and second in bits 7:0.
- R5: A literal-count byte of 0x00 means 256 literals.
- R6: After a chunk's literals, the next byte is a repeat count r, and the last literal is emitted r more times. When r is 0 there is no repeat, and the following byte is the next literal count.
- R7: A total-count value of 0x00 means 256 pixels.
- R8: Once the total has been emitted, no further byte is taken (`in_ready` stays low). This includes a repeat byte when the literals alone completed the total.
- R9: A literal count above the remaining total is cut to the remaining total, and `overrun` is set. `overrun` stays set until the next accepted `start`.
- R10: A repeat count above the remaining total is cut to the remaining total, and `overrun` is set.
- R11: `out_last` is high on the final pixel of a command and on no other. After that pixel's handshake, `busy` is low.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_pixel` and `out_last` hold their values.
- R13: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a command; taken only while idle |
| start_offset | input | ADDR_W | Address of the first pixel |
| total_count | input | 8 | Pixels in the command, 0 means 256 |
| mode16 | input | 1 | 1: 16-bit pixels, 0: 8-bit pixels |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte accepted this cycle |
| out_valid | output | 1 | Pixel write valid |
| out_addr | output | ADDR_W | Pixel address |
| out_pixel | output | 16 | Pixel value |
| out_last | output | 1 | Final pixel of the command |
| out_ready | input | 1 | Pixel write accepted |
| overrun | output | 1 | A count was cut at the total |
| busy | output | 1 | Command in progress or pixel pending |

## Verification
The hardest case to reach from the ports is a chunk whose literals end exactly on the total while a repeat byte is waiting on the input. That repeat byte must be left unconsumed. To reach it, the bench computes from its own model how many bytes a command consumes and feeds exactly that many. It then holds an extra byte valid and confirms `in_ready` stays low. Clipped counts are reached with counts larger than the remaining total. The same stimulus is also run with output stalls, so that decisions made while a pixel is held are exercised.

// File: rtl/rle_pkg.sv
package rle_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_COUNT  = 3'd1,
        S_PIXEL  = 3'd2,
        S_RPTCNT = 3'd3,
        S_REPEAT = 3'd4
    } state_e;
endpackage

// File: rtl/rle_count_clip.sv
module rle_count_clip #(
    parameter int W = 9
) (
    input  logic [W-1:0] req,
    input  logic [W-1:0] limit,
    output logic [W-1:0] eff,
    output logic         over
);
    assign over = (req > limit);
    assign eff  = over ? limit : req;
endmodule

// File: rtl/rle_pixel_expander.sv
module rle_pixel_expander
    import rle_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_offset,
    input  logic [7:0]        total_count,
    input  logic              mode16,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [15:0]       out_pixel,
    output logic              out_last,
    input  logic              out_ready,
    output logic              overrun,
    output logic              busy
);
    localparam int BYTE_W = 8;
    localparam int REM_W  = BYTE_W + 1;
    localparam int PIX_W  = 2 * BYTE_W;

    typedef struct packed {
        state_e              state;
        logic                mode16;
        logic                half;
        logic [BYTE_W-1:0]   hi;
        logic [ADDR_W-1:0]   addr;
        logic [REM_W-1:0]    remain;
        logic [REM_W-1:0]    lit_left;
        logic [BYTE_W-1:0]   rep_left;
        logic [PIX_W-1:0]    last_px;
        logic                ovr;
        logic                ovalid;
        logic [ADDR_W-1:0]   oaddr;
        logic [PIX_W-1:0]    opx;
        logic                olast;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              out_free;
    logic              in_fire;
    logic [REM_W-1:0]  lit_req, lit_eff, rep_req, rep_eff;
    logic              lit_over, rep_over;
    logic [PIX_W-1:0]  lit_px;
    logic              final_px;

    // count byte decode: 0x00 stands for 256
    assign lit_req = {~|in_data, in_data};
    assign rep_req = {1'b0, in_data};

    rle_count_clip #(.W(REM_W)) u_lit_clip (
        .req(lit_req), .limit(regs_q.remain), .eff(lit_eff), .over(lit_over)
    );
    rle_count_clip #(.W(REM_W)) u_rep_clip (
        .req(rep_req), .limit(regs_q.remain), .eff(rep_eff), .over(rep_over)
    );

    assign out_free = !regs_q.ovalid || out_ready;
    assign lit_px   = regs_q.mode16 ? {regs_q.hi, in_data} : {{BYTE_W{1'b0}}, in_data};
    assign final_px = (regs_q.remain == REM_W'(1));

    always_comb begin
        case (regs_q.state)
            S_COUNT, S_RPTCNT: in_ready = 1'b1;
            S_PIXEL:           in_ready = (regs_q.mode16 && !regs_q.half) || out_free;
            default:           in_ready = 1'b0;
        endcase
    end
    assign in_fire = in_valid && in_ready;

    always_comb begin
        regs_d = regs_q;
        if (regs_q.ovalid && out_ready) regs_d.ovalid = 1'b0;
        case (regs_q.state)
            S_IDLE: begin
                if (start && !regs_q.ovalid) begin
                    regs_d.state  = S_COUNT;
                    regs_d.mode16 = mode16;
                    regs_d.addr   = start_offset;
                    regs_d.remain = {~|total_count, total_count};
                    regs_d.ovr    = 1'b0;
                    regs_d.half   = 1'b0;
                end
            end
            S_COUNT: begin
                if (in_fire) begin
                    regs_d.lit_left = lit_eff;
                    regs_d.ovr      = regs_q.ovr | lit_over;
                    regs_d.half     = 1'b0;
                    regs_d.state    = S_PIXEL;
                end
            end
            S_PIXEL: begin
                if (in_fire) begin
                    if (regs_q.mode16 && !regs_q.half) begin
                        regs_d.half = 1'b1;
                        regs_d.hi   = in_data;
                    end else begin
                        regs_d.half     = 1'b0;
                        regs_d.last_px  = lit_px;
                        regs_d.ovalid   = 1'b1;
                        regs_d.oaddr    = regs_q.addr;
                        regs_d.opx      = lit_px;
                        regs_d.olast    = final_px;
                        regs_d.addr     = regs_q.addr + 1'b1;
                        regs_d.remain   = regs_q.remain - 1'b1;
                        regs_d.lit_left = regs_q.lit_left - 1'b1;
                        if (final_px)
                            regs_d.state = S_IDLE;
                        else if (regs_q.lit_left == REM_W'(1))
                            regs_d.state = S_RPTCNT;
                    end
                end
            end
            S_RPTCNT: begin
                if (in_fire) begin
                    regs_d.ovr = regs_q.ovr | rep_over;
                    if (rep_eff == '0) begin
                        regs_d.state = S_COUNT;
                    end else begin
                        regs_d.rep_left = rep_eff[BYTE_W-1:0];
                        regs_d.state    = S_REPEAT;
                    end
                end
            end
            S_REPEAT: begin
                if (out_free) begin
                    regs_d.ovalid   = 1'b1;
                    regs_d.oaddr    = regs_q.addr;
                    regs_d.opx      = regs_q.last_px;
                    regs_d.olast    = final_px;
                    regs_d.addr     = regs_q.addr + 1'b1;
                    regs_d.remain   = regs_q.remain - 1'b1;
                    regs_d.rep_left = regs_q.rep_left - 1'b1;
                    if (final_px)
                        regs_d.state = S_IDLE;
                    else if (regs_q.rep_left == BYTE_W'(1))
                        regs_d.state = S_COUNT;
                end
            end
            default: regs_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign out_valid = regs_q.ovalid;
    assign out_addr  = regs_q.oaddr;
    assign out_pixel = regs_q.opx;
    assign out_last  = regs_q.olast;
    assign overrun   = regs_q.ovr;
    assign busy      = (regs_q.state != S_IDLE) || regs_q.ovalid;
endmodule

// File: rtl/rle_expander_checker.sv
module rle_expander_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [15:0]       out_pixel,
    input logic              out_last,
    input logic              out_ready,
    input logic              overrun,
    input logic              busy
);
    logic              out_fire;
    logic              prev_ok_q;
    logic [ADDR_W-1:0] prev_addr_q;

    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ok_q   <= 1'b0;
            prev_addr_q <= '0;
        end else if (out_fire) begin
            prev_ok_q   <= !out_last;
            prev_addr_q <= out_addr;
        end
    end

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_pixel) && $stable(out_last)); // R12

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && prev_ok_q |-> out_addr == prev_addr_q + 1'b1); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && out_last |=> !busy); // R11

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && overrun |=> overrun); // R9

    AST_NO_INPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready); // R8
endmodule

bind rle_pixel_expander rle_expander_checker #(.ADDR_W(ADDR_W)) u_rle_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_pixel(out_pixel), .out_last(out_last),
    .out_ready(out_ready), .overrun(overrun), .busy(busy)
);

// File: tb/test_rle_pixel_expander.sv
module test_rle_pixel_expander;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_offset = '0;
    logic [7:0]        total_count = '0;
    logic              mode16 = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [ADDR_W-1:0] out_addr;
    logic [15:0]       out_pixel;
    logic              out_last;
    logic              out_ready = 1'b0;
    logic              overrun;
    logic              busy;

    rle_pixel_expander #(.ADDR_W(ADDR_W)) i_rle_pixel_expander (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // stimulus bytes and expectation computed by the reference model
    logic [7:0]  bytes [0:299];
    logic [15:0] exp_px [0:299];
    int          exp_n, exp_used;
    bit          exp_ovr;

    function automatic void model(input bit m16, input logic [7:0] tot);
        int rem, idx, c, r;
        logic [15:0] px;
        rem = (tot == 0) ? 256 : int'(tot);
        idx = 0; exp_n = 0; exp_ovr = 0; px = '0;
        while (rem > 0) begin
            c = int'(bytes[idx]); idx++;
            if (c == 0) c = 256;
            if (c > rem) begin exp_ovr = 1; c = rem; end
            for (int k = 0; k < c; k++) begin
                if (m16) begin px = {bytes[idx], bytes[idx+1]}; idx += 2; end
                else begin px = {8'h00, bytes[idx]}; idx++; end
                exp_px[exp_n] = px; exp_n++;
            end
            rem -= c;
            if (rem == 0) break;
            r = int'(bytes[idx]); idx++;
            if (r > rem) begin exp_ovr = 1; r = rem; end
            for (int k = 0; k < r; k++) begin exp_px[exp_n] = px; exp_n++; end
            rem -= r;
        end
        exp_used = idx;
    endfunction

    task automatic run(input bit m16, input logic [23:0] off, input logic [7:0] tot,
                       input bit stall, input bit poke, input string tag);
        model(m16, tot);
        @(negedge clk);
        start = 1; start_offset = off; total_count = tot; mode16 = m16;
        @(negedge clk);
        start = 0;
        fork
            begin : drive
                for (int i = 0; i < exp_used; i++) begin
                    int w;
                    @(negedge clk);
                    in_valid = 1; in_data = bytes[i];
                    #1;
                    w = 0;
                    while (!in_ready && w < 3000) begin @(negedge clk); #1; w++; end
                    if (poke && i == 0) begin
                        @(negedge clk);
                        in_valid = 0;
                        start = 1; start_offset = 24'hABCDEF; total_count = 8'd1; mode16 = !m16;
                        @(negedge clk);
                        start = 0;
                        // R13: a start while busy must leave the command unchanged
                    end
                end
                @(negedge clk);
                in_valid = 0;
            end
            begin : collect
                int n, t;
                bit held;
                logic [23:0] h_addr; logic [15:0] h_px; logic h_last;
                n = 0; t = 0; held = 0; h_addr = '0; h_px = '0; h_last = 0;
                while (n < exp_n && t < 4000) begin
                    @(negedge clk);
                    out_ready = !(stall && (cyc % 3 == 1));
                    #1;
                    t++;
                    if (held) begin
                        check(out_valid && out_addr == h_addr && out_pixel == h_px && out_last == h_last,
                              "R12 hold", {out_addr, out_pixel}, {h_addr, h_px});
                    end
                    if (out_valid && out_ready) begin
                        check(out_pixel == exp_px[n], {tag, " pixel"}, out_pixel, exp_px[n]);
                        check(out_addr == off + 24'(n), "R2 address", out_addr, off + 24'(n));
                        check(out_last == (n == exp_n - 1), "R11 last flag", out_last, (n == exp_n - 1));
                        n++;
                        held = 0;
                    end else begin
                        held = out_valid;
                        h_addr = out_addr; h_px = out_pixel; h_last = out_last;
                    end
                end
                check(n == exp_n, {tag, " pixel count"}, n, exp_n);
                @(negedge clk);
                out_ready = 0;
            end
        join
        @(negedge clk); #1;
        check(!busy, "R11 idle after last", busy, 0);
        check(overrun == exp_ovr, "R9/R10 overrun flag", overrun, exp_ovr);
        // R8: an extra byte offered after completion is not taken
        in_valid = 1; in_data = 8'h5A;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check(!in_ready, "R8 no extra byte", in_ready, 0);
        end
        in_valid = 0;
    endtask

    typedef struct packed {
        logic         m16;
        logic [23:0]  off;
        logic [7:0]   tot;
        logic         stall;
        logic [127:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [0:NV-1] = '{
        // R3 R6: two literals then three repeats
        '{1'b0, 24'h000010, 8'd5, 1'b0, 128'h02112203_00000000_00000000_00000000},
        // R4 R8: 16-bit, literals finish the total, no repeat byte
        '{1'b1, 24'h000100, 8'd4, 1'b1, 128'h01ABCD01_02123456_78000000_00000000},
        // R2 R6: address wrap and a zero repeat
        '{1'b0, 24'hFFFFFE, 8'd4, 1'b1, 128'h01550003_66778800_00000000_00000000},
        // R9: literal count clipped
        '{1'b0, 24'h000200, 8'd3, 1'b0, 128'h05010203_00000000_00000000_00000000},
        // R10: repeat count clipped
        '{1'b1, 24'h000300, 8'd3, 1'b1, 128'h01F80009_00000000_00000000_00000000},
        // R7: total of 0 means 256
        '{1'b0, 24'h001000, 8'd0, 1'b0, 128'h01AAFF00_00000000_00000000_00000000}
    };

    initial begin
        // R1: reset state
        #1;
        check(!out_valid && !in_ready && !busy && !overrun, "R1 reset outputs",
              {out_valid, in_ready, busy, overrun}, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check(!out_valid && !in_ready && !busy && !overrun, "R1 after release",
              {out_valid, in_ready, busy, overrun}, 0);

        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 300; i++) bytes[i] = 8'h00;
            for (int i = 0; i < 16; i++) bytes[i] = VECS[v].data[127 - 8*i -: 8];
            run(VECS[v].m16, VECS[v].off, VECS[v].tot, VECS[v].stall, 1'b0, $sformatf("vec%0d", v));
        end

        // R5: literal count of 0 gives 256 literals
        bytes[0] = 8'h00;
        for (int i = 1; i <= 256; i++) bytes[i] = 8'(i * 7);
        run(1'b0, 24'h020000, 8'd0, 1'b1, 1'b0, "R5 count zero");

        // R13: start while busy is ignored
        for (int i = 0; i < 300; i++) bytes[i] = 8'h00;
        bytes[0] = 8'h02; bytes[1] = 8'h31; bytes[2] = 8'h32; bytes[3] = 8'h02;
        bytes[4] = 8'h01; bytes[5] = 8'h44;
        run(1'b0, 24'h000500, 8'd5, 1'b0, 1'b1, "R13 start ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule